// File: doc/BRIEF.md
# Configuration Frame Parity Generator

This block produces the 14-bit error-check field carried at the tail of every configuration frame. Frame payload enters MSB first, `DATA_W` bits per valid cycle, and goes into a 14-bit CRC with generator 0x202D. Positions whose contents may change while the device runs, such as RAM initial values, are flagged on a per-bit mask input. Flagged bits are replaced by zero before they reach the CRC, so the parity depends only on the fixed part of the frame.

The CRC restarts from zero on every start-of-frame strobe. This holds whichever chunk of the configuration a frame belongs to, and it holds when the previous frame was cut short. In generate mode the finished parity appears at the output so it can be appended to the frame. In check mode the 14 received parity bits follow the last payload word on the same data input. They are compared with the computed value, and a mismatch flag is raised and held until the next frame starts.

Top module: `frame_parity_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `parity` is zero and `done` and `mismatch` are low.
- R2: A cycle with `sof` high clears the CRC to zero and starts a new frame, whatever the state of any frame in progress. If `valid` is also high in that cycle, the word is the first payload word and is folded into the cleared CRC.
- R3: The parity is a 14-bit CRC with polynomial 0x202D, initial value zero and no final inversion. For each payload bit the feedback is `crc[13]` XOR bit, the register shifts left, and 0x202D is XORed in when the feedback is 1. A frame with the single 7-bit word 0000001 gives 0x202D.
- R4: A payload bit whose `mask` bit at the same index is 1 enters the CRC as 0. A frame with every bit masked gives parity zero.
- R5: Each valid payload word gives up its `DATA_W` bits starting at `data[DATA_W-1]` and ending at `data[0]`.
- R6: Cycles with `valid` low leave the CRC unchanged. Valid words that arrive after a frame is finished and before the next `sof` are ignored, and `parity` keeps its value.
- R7: In generate mode, `done` pulses for one cycle in the cycle after the word marked `eof` is taken, and `parity` then holds the final CRC.
- R8: In check mode, the `14/DATA_W` valid words after the `eof` word carry the received parity, most significant bits first. These words are not masked and do not enter the CRC. `done` pulses in the cycle after the last of them, and `mismatch` rises in that same cycle if the received value differs from the computed one.
- R9: `mismatch` stays at its value until the next `sof`, which clears it.
- R10: The mode is taken from `check_mode` in the `sof` cycle. Changing `check_mode` later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start of frame: clears the CRC and latches the mode |
| valid | input | 1 | The word on `data` is taken this cycle |
| eof | input | 1 | Qualifies the last payload word of the frame |
| check_mode | input | 1 | 1 = compare against received parity, 0 = generate |
| data | input | DATA_W | Payload or received-parity word, MSB first |
| mask | input | DATA_W | 1 forces the bit at the same index to zero before the CRC |
| parity | output | 14 | Current CRC value, final once `done` pulses |
| done | output | 1 | One-cycle pulse when the parity is final or the compare is made |
| mismatch | output | 1 | Received parity differed from computed parity, held until next `sof` |

## Verification
The bench builds the block with `DATA_W` = 7. With that width the received parity takes two words, so the trailer word counting, the ordering of bits inside a word and the per-index masking are all exercised. The default `DATA_W` = 1 serial build is covered by elaboration. The serial path is the same loop with one iteration, so the 7-bit build also reaches the shift-and-feedback logic of the serial case.

// File: rtl/frame_parity_gen.sv
module frame_parity_gen #(
  parameter int DATA_W = 1,
  parameter int PAR_W  = 14,
  parameter logic [PAR_W-1:0] POLY = 14'h202D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              valid,
  input  logic              eof,
  input  logic              check_mode,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  output logic [PAR_W-1:0]  parity,
  output logic              done,
  output logic              mismatch
);
  localparam int TR_WORDS = PAR_W / DATA_W;
  localparam int CW = $clog2(TR_WORDS + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_BODY = 2'd1, S_TAIL = 2'd2} state_t;

  state_t             state;
  logic               mode_q;
  logic [PAR_W-1:0]   crc, rx;
  logic [CW-1:0]      cnt;

  function automatic logic [PAR_W-1:0] step(logic [PAR_W-1:0] c, logic [DATA_W-1:0] d);
    logic fb;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[PAR_W-1] ^ d[i];
      c  = {c[PAR_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  logic [PAR_W-1:0]        base;
  logic                    take, last, mode_n, tail_take, tail_last;
  logic [PAR_W+DATA_W-1:0] rx_cat;

  assign base      = sof ? '0 : crc;
  assign take      = valid && (sof || state == S_BODY);
  assign last      = take && eof;
  assign mode_n    = sof ? check_mode : mode_q;
  assign tail_take = valid && !sof && state == S_TAIL;
  assign tail_last = tail_take && cnt == CW'(TR_WORDS - 1);
  assign rx_cat    = {rx, data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= 1'b0;
      crc      <= '0;
      rx       <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sof) begin
        mode_q   <= check_mode;
        mismatch <= 1'b0;
        cnt      <= '0;
        state    <= S_BODY;
      end
      if (take)
        crc <= step(base, data & ~mask);
      else if (sof)
        crc <= '0;
      if (last) begin
        state <= mode_n ? S_TAIL : S_IDLE;
        done  <= !mode_n;
      end
      if (tail_take) begin
        rx  <= rx_cat[PAR_W-1:0];
        cnt <= cnt + 1'b1;
      end
      if (tail_last) begin
        state    <= S_IDLE;
        done     <= 1'b1;
        mismatch <= rx_cat[PAR_W-1:0] != crc;
      end
    end
  end

  assign parity = crc;
endmodule

module frame_parity_chk #(
  parameter int PAR_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             valid,
  input logic             done,
  input logic             mismatch,
  input logic             mode_q,
  input logic [1:0]       state,
  input logic [PAR_W-1:0] parity
);
  AST_SOF_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) sof && !valid |=> parity == '0); // R2
  AST_SOF_DROPS:   assert property (@(posedge clk) disable iff (!rst_n) sof |=> !mismatch); // R9
  AST_FLAG_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) $fell(mismatch) |-> $past(sof)); // R9
  AST_FLAG_RISE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(mismatch) |-> done); // R8
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done || $past(sof))); // R7
  AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !sof && !(valid && state == 2'd1) |=> $stable(parity)); // R6
  AST_GEN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done && !mode_q |-> !mismatch); // R10
endmodule

bind frame_parity_gen frame_parity_chk #(.PAR_W(PAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .valid(valid), .done(done),
  .mismatch(mismatch), .mode_q(mode_q), .state(state), .parity(parity)
);

// File: tb/frame_parity_gen_tb.sv
`timescale 1ns/1ps
module frame_parity_gen_tb;
  localparam int W = 7;

  logic clk = 0, rst_n = 0, sof = 0, valid = 0, eof = 0, check_mode = 0;
  logic [W-1:0] data = '0, mask = '0;
  logic [13:0] parity;
  logic done, mismatch;

  int vectors = 0, fails = 0, cycles = 0;
  logic [W-1:0] pay [0:15];
  logic [W-1:0] msk [0:15];

  always #4 clk = ~clk;

  frame_parity_gen #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .valid(valid), .eof(eof),
    .check_mode(check_mode), .data(data), .mask(mask),
    .parity(parity), .done(done), .mismatch(mismatch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] ref_crc(input int nw);
    logic [13:0] c = '0;
    logic b, fb;
    for (int w = 0; w < nw; w++)
      for (int i = W - 1; i >= 0; i--) begin
        b  = pay[w][i] & ~msk[w][i];
        fb = c[13] ^ b;
        c  = {c[12:0], 1'b0} ^ (fb ? 14'h202D : 14'h0);
      end
    return c;
  endfunction

  task automatic fill(input int nw, input int seed, input bit masked);
    for (int i = 0; i < nw; i++) begin
      pay[i] = W'(i * 37 + seed * 11 + 5);
      msk[i] = masked ? W'(i * 13 + seed) : '0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sof = 0; valid = 0; eof = 0; mask = '0;
  endtask

  task automatic send(input int nw, input bit cm, input logic [13:0] rx, input bit gap, input bit tmask);
    check_mode = cm;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      if (i == 1) check_mode = !cm;
      sof = (i == 0); valid = 1; eof = (i == nw - 1);
      data = pay[i]; mask = msk[i];
      if (gap && i < nw - 1) idle();
    end
    if (cm) begin
      @(negedge clk);
      sof = 0; eof = 0; valid = 1; data = rx[13:7]; mask = tmask ? '1 : '0;
      @(negedge clk);
      data = rx[6:0];
    end
    idle();
  endtask

  task automatic t_reset();
    chk("R1 parity", parity, 0);
    chk("R1 done", done, 0);
    chk("R1 mismatch", mismatch, 0);
  endtask

  task automatic t_known();
    pay[0] = 7'b0000001; msk[0] = '0;
    send(1, 0, 0, 0, 0);
    chk("R7 done", done, 1);
    chk("R3 known value", parity, 14'h202D);
    idle();
    chk("R7 single pulse", done, 0);
  endtask

  task automatic t_gen();
    fill(9, 1, 0);
    send(9, 0, 0, 0, 0);
    chk("R3 R5 nine words", parity, ref_crc(9));
    chk("R10 gen done", done, 1);
    fill(3, 7, 0);
    send(3, 0, 0, 0, 0);
    chk("R5 three words", parity, ref_crc(3));
  endtask

  task automatic t_mask();
    fill(5, 3, 0);
    for (int i = 0; i < 5; i++) begin pay[i] = pay[i] | 7'h01; msk[i] = '1; end
    send(5, 0, 0, 0, 0);
    chk("R4 all masked", parity, 0);
    fill(6, 4, 1);
    send(6, 0, 0, 0, 0);
    chk("R4 partial mask", parity, ref_crc(6));
  endtask

  task automatic t_gap();
    logic [13:0] held;
    fill(6, 9, 1);
    send(6, 0, 0, 1, 0);
    chk("R6 gapped frame", parity, ref_crc(6));
    held = parity;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); valid = 1; data = W'(i + 3); eof = (i == 2);
    end
    idle();
    chk("R6 ignored after frame", parity, held);
    chk("R6 no done", done, 0);
  endtask

  task automatic t_check();
    logic [13:0] good;
    fill(8, 5, 1);
    good = ref_crc(8);
    send(8, 1, good, 0, 1);
    chk("R8 good done", done, 1);
    chk("R8 good no flag", mismatch, 0);
    chk("R8 parity kept", parity, good);
    send(8, 1, good ^ 14'h0400, 0, 0);
    chk("R8 bad done", done, 1);
    chk("R8 bad flag", mismatch, 1);
    for (int i = 0; i < 4; i++) idle();
    chk("R9 flag held", mismatch, 1);
    @(negedge clk); sof = 1; valid = 0;
    idle();
    chk("R9 flag cleared", mismatch, 0);
    chk("R2 sof clears", parity, 0);
  endtask

  task automatic t_abort();
    fill(3, 2, 0);
    check_mode = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sof = (i == 0); valid = 1; eof = 0; data = pay[i]; mask = '0;
    end
    fill(4, 6, 1);
    send(4, 0, 0, 0, 0);
    chk("R2 restart mid frame", parity, ref_crc(4));
    chk("R2 done", done, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_known();
    t_gen();
    t_mask();
    t_gap();
    t_check();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule